// File: doc/BRIEF.md
# Receive Elastic Buffer with Aligned Status

This block absorbs the small frequency difference between a link partner's transmit clock and the local receive clock. Decoded 8-bit symbols enter in the recovered-clock domain. Each symbol comes with a control (K) flag and two error flags, one for a failed 8b/10b decode and one for a disparity error. The symbols cross a small dual-clock FIFO with Gray-coded pointers. They leave in the local domain with a valid flag and a 3-bit status code.

The buffer keeps its fill near the middle by adjusting only skip symbols (K28.0) that sit inside a skip ordered set, which is a COM (K28.5) followed by skip symbols. The write side deletes one skip when its view of the fill is high. The read side repeats one skip when its view is low. Each side makes at most one adjustment per ordered set.

Every adjustment and every error is reported on the status output in the same cycle as the output symbol it concerns. A byte that failed decoding is replaced by the EDB control symbol. A symbol lost to a full buffer is reported on the next symbol that survives. An empty buffer drops the valid flag.

Top module: `rxeb_top`

## Requirements
- R1: After reset, and until the read side first sees a fill of at least PRIME entries, out_valid is 0 and out_status is 000.
- R2: Symbols other than skips leave in the order they arrived, each exactly once, unless the buffer was full when they arrived.
- R3: A symbol with in_dec_err set leaves as EDB (data 0xFE, K=1) with status 100 in the same output cycle.
- R4: A symbol with only in_disp_err set leaves with its data and K flag unchanged and status 111.
- R5: A K28.0 symbol (data 0x1C, K=1) counts as a skip only when it directly follows a COM (0xBC, K=1) or another skip. Any other K28.0 passes through as ordinary data and is never deleted or repeated.
- R6: When the write-side fill exceeds HI, the first skip of an ordered set is deleted. The symbol that followed it leaves with status 010.
- R7: When the read-side fill is below LO and a skip is at the head of the buffer, that skip is output twice. The first copy carries status 001.
- R8: Across all ordered sets, at most one skip is deleted and at most one skip is inserted per ordered set. The count of COM symbols on the output resets this per-set tally.
- R9: A symbol that arrives while the buffer is full is dropped. The next stored symbol leaves with status 101.
- R10: Once primed, an empty buffer gives out_valid 0 with status 110. Status 110 never appears with out_valid 1.
- R11: When one output symbol carries several conditions, the reported code follows this order, highest first: decode error (100), disparity error (111), overflow (101), skip deleted (010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| in_valid | input | 1 | Input symbol present |
| in_data | input | 8 | Decoded symbol byte |
| in_k | input | 1 | Input symbol is a control symbol |
| in_dec_err | input | 1 | Input byte failed 8b/10b decoding |
| in_disp_err | input | 1 | Input byte had a disparity error |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_valid | output | 1 | Output symbol valid |
| out_data | output | 8 | Output symbol byte |
| out_k | output | 1 | Output symbol is a control symbol |
| out_status | output | 3 | Receive status for this output cycle |

## Verification
The assertions assume the following about the inputs:
- Every skip ordered set holds at least two skips.
- Ordered sets recur often enough that the skip adjustments can keep pace with the clock offset.
- The two resets are each held for several cycles of their own clock.

The stimulus keeps within these limits in three ways. It sends sets of three skips every 200 symbols. It holds the offset at 300 ppm in each direction, except in one deliberate overrun stretch that carries no sets. It places injected errors well away from the symbol that follows a set, so that a deleted-skip report is never hidden by an error of higher priority.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;

  localparam logic [7:0] SYM_COM = 8'hBC;  // K28.5
  localparam logic [7:0] SYM_SKP = 8'h1C;  // K28.0
  localparam logic [7:0] SYM_EDB = 8'hFE;  // K30.7

  typedef enum logic [2:0] {
    ST_OK        = 3'b000,
    ST_SKP_ADD   = 3'b001,
    ST_SKP_DEL   = 3'b010,
    ST_DEC_ERR   = 3'b100,
    ST_OVERFLOW  = 3'b101,
    ST_UNDERFLOW = 3'b110,
    ST_DISP_ERR  = 3'b111
  } rx_status_e;

  // One stored symbol together with the conditions that must be reported with it.
  typedef struct packed {
    logic       ovf;   // a symbol was dropped just before this one
    logic       del;   // a skip was deleted just before this one
    logic       disp;  // disparity error on this symbol
    logic       dec;   // decode error (data already replaced by EDB)
    logic       skp;   // recognised skip inside an ordered set
    logic       k;
    logic [7:0] data;
  } eb_entry_t;

  function automatic rx_status_e entry_status(eb_entry_t e);
    if (e.dec)       return ST_DEC_ERR;
    else if (e.disp) return ST_DISP_ERR;
    else if (e.ovf)  return ST_OVERFLOW;
    else if (e.del)  return ST_SKP_DEL;
    else             return ST_OK;
  endfunction

endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rxeb_ram.sv
module rxeb_ram #(
  parameter int AW = 4,
  parameter int DW = 14
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxeb_wr_ctrl.sv
module rxeb_wr_ctrl
  import rxeb_pkg::*;
#(
  parameter int AW = 4,
  parameter int HI = 13
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_k,
  input  logic          in_dec_err,
  input  logic          in_disp_err,
  input  logic [AW:0]   rd_gray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output eb_entry_t     wentry,
  output logic [AW:0]   wr_gray,
  output logic [AW:0]   wr_fill
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nxt, rbin_s;
  logic          in_set, set_adj, pend_del, pend_ovf;
  logic          is_com, is_skp, full, drop_skp;

  always_comb begin
    rbin_s[PW-1] = rd_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rd_gray_s[i];
  end

  assign wr_fill  = wbin - rbin_s;
  assign full     = (wr_fill == PW'(DEPTH));
  assign wbin_nxt = wbin + PW'(1);

  assign is_com   = !in_dec_err && in_k && (in_data == SYM_COM);
  assign is_skp   = !in_dec_err && in_k && (in_data == SYM_SKP) && in_set;
  assign drop_skp = is_skp && !set_adj && (wr_fill > PW'(HI));

  assign we    = in_valid && !drop_skp && !full;
  assign waddr = wbin[AW-1:0];

  always_comb begin
    wentry.ovf  = pend_ovf;
    wentry.del  = pend_del;
    wentry.disp = in_disp_err;
    wentry.dec  = in_dec_err;
    wentry.skp  = is_skp;
    wentry.k    = in_dec_err | in_k;
    wentry.data = in_dec_err ? SYM_EDB : in_data;
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin     <= '0;
      wr_gray  <= '0;
      in_set   <= 1'b0;
      set_adj  <= 1'b0;
      pend_del <= 1'b0;
      pend_ovf <= 1'b0;
    end else if (in_valid) begin
      in_set <= is_com | is_skp;
      if (is_com)        set_adj <= 1'b0;
      else if (drop_skp) set_adj <= 1'b1;
      if (drop_skp) begin
        pend_del <= 1'b1;
      end else if (full) begin
        pend_ovf <= 1'b1;
      end else begin
        pend_del <= 1'b0;
        pend_ovf <= 1'b0;
        wbin     <= wbin_nxt;
        wr_gray  <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/rxeb_rd_ctrl.sv
module rxeb_rd_ctrl
  import rxeb_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LO    = 6,
  parameter int PRIME = 7
) (
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic [AW:0]   wr_gray_s,
  input  eb_entry_t     head,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rd_gray,
  output logic [AW:0]   rd_fill,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_k,
  output logic [2:0]    out_status
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s;
  logic          primed, set_adj, empty, ins;

  always_comb begin
    wbin_s[PW-1] = wr_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wr_gray_s[i];
  end

  assign rd_fill  = wbin_s - rbin;
  assign empty    = (rd_fill == '0);
  assign rbin_nxt = rbin + PW'(1);
  assign raddr    = rbin[AW-1:0];
  assign ins      = head.skp && !set_adj && (rd_fill < PW'(LO));

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin       <= '0;
      rd_gray    <= '0;
      primed     <= 1'b0;
      set_adj    <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_k      <= 1'b0;
      out_status <= ST_OK;
    end else if (!primed) begin
      out_valid  <= 1'b0;
      out_status <= ST_OK;
      if (rd_fill >= PW'(PRIME)) primed <= 1'b1;
    end else if (empty) begin
      out_valid  <= 1'b0;
      out_status <= ST_UNDERFLOW;
    end else begin
      out_valid <= 1'b1;
      out_data  <= head.data;
      out_k     <= head.k;
      if (ins) begin
        out_status <= ST_SKP_ADD;
        set_adj    <= 1'b1;
      end else begin
        out_status <= entry_status(head);
        rbin       <= rbin_nxt;
        rd_gray    <= rbin_nxt ^ (rbin_nxt >> 1);
        if (head.k && head.data == SYM_COM) set_adj <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxeb_top.sv
module rxeb_top
  import rxeb_pkg::*;
#(
  parameter int AW    = 4,
  parameter int HI    = 13,
  parameter int LO    = 6,
  parameter int PRIME = 7
) (
  input  logic       wr_clk,
  input  logic       wr_rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_k,
  input  logic       in_dec_err,
  input  logic       in_disp_err,
  input  logic       rd_clk,
  input  logic       rd_rst,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_k,
  output logic [2:0] out_status
);
  localparam int PW = AW + 1;
  localparam int EW = $bits(eb_entry_t);

  logic          we;
  logic [AW-1:0] waddr, raddr;
  eb_entry_t     wentry, rentry;
  logic [EW-1:0] rdata;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [PW-1:0] wr_fill, rd_fill;

  rxeb_wr_ctrl #(.AW(AW), .HI(HI)) u_wr (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_data(in_data),
    .in_k(in_k), .in_dec_err(in_dec_err), .in_disp_err(in_disp_err),
    .rd_gray_s(rd_gray_s), .we(we), .waddr(waddr), .wentry(wentry),
    .wr_gray(wr_gray), .wr_fill(wr_fill)
  );

  rxeb_ram #(.AW(AW), .DW(EW)) u_ram (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wentry),
    .raddr(raddr), .rdata(rdata)
  );

  assign rentry = eb_entry_t'(rdata);

  rxeb_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s)
  );

  rxeb_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s)
  );

  rxeb_rd_ctrl #(.AW(AW), .LO(LO), .PRIME(PRIME)) u_rd (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .wr_gray_s(wr_gray_s), .head(rentry),
    .raddr(raddr), .rd_gray(rd_gray), .rd_fill(rd_fill),
    .out_valid(out_valid), .out_data(out_data), .out_k(out_k),
    .out_status(out_status)
  );
endmodule

// File: rtl/rxeb_chk.sv
module rxeb_chk
  import rxeb_pkg::*;
#(
  parameter int AW = 4
) (
  input logic        wr_clk,
  input logic        wr_rst,
  input logic        rd_clk,
  input logic        rd_rst,
  input logic        out_valid,
  input logic [7:0]  out_data,
  input logic        out_k,
  input logic [2:0]  out_status,
  input logic [AW:0] wr_fill,
  input logic [AW:0] rd_fill
);
  localparam int DEPTH = 1 << AW;

  AST_IDLE_STATUS: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !out_valid |-> (out_status == ST_OK || out_status == ST_UNDERFLOW)); // R1

  AST_UNDERFLOW_INVALID: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_status == ST_UNDERFLOW |-> !out_valid); // R10

  AST_EDB_ON_DECODE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_status == ST_DEC_ERR |-> (out_valid && out_k && out_data == SYM_EDB)); // R3

  AST_ADD_ON_SKIP: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_status == ST_SKP_ADD |-> (out_valid && out_k && out_data == SYM_SKP)); // R7

  AST_ADD_REPEATS_SKIP: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_status == ST_SKP_ADD |=> (out_valid && out_k && out_data == SYM_SKP)); // R7

  AST_ADD_NOT_BACK_TO_BACK: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_status == ST_SKP_ADD |=> out_status != ST_SKP_ADD); // R8

  AST_NO_OVERFILL: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_fill <= (AW+1)'(DEPTH)); // R9

  AST_RD_FILL_BOUND: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_fill <= (AW+1)'(DEPTH)); // R2
endmodule

bind rxeb_top rxeb_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .out_valid(out_valid), .out_data(out_data), .out_k(out_k),
  .out_status(out_status), .wr_fill(wr_fill), .rd_fill(rd_fill)
);

// File: tb/tb_rxeb_top.sv
`timescale 1ns/1ps
module tb_rxeb_top;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic in_valid = 1'b0, in_k = 1'b0, in_dec_err = 1'b0, in_disp_err = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_k;
  logic [7:0] out_data;
  logic [2:0] out_status;

  realtime wr_half = 10.0;
  always #(wr_half) wr_clk = ~wr_clk;
  always #10 rd_clk = ~rd_clk;

  rxeb_top dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_data(in_data),
    .in_k(in_k), .in_dec_err(in_dec_err), .in_disp_err(in_disp_err),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .out_valid(out_valid),
    .out_data(out_data), .out_k(out_k), .out_status(out_status)
  );

  int checks = 0, errors = 0;
  bit [11:0] exp_q[$];           // {status, k, data}
  int skp_in = 0, skp_out = 0, adds = 0, dels = 0, ovfs = 0, unders = 0;
  int set_adds = 0, set_dels = 0;
  bit ctx = 0, mon_en = 0, done = 0;
  logic [7:0] dcnt = 8'h00;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] d, logic k, logic dec, logic disp);
    @(negedge wr_clk);
    in_valid = 1'b1; in_data = d; in_k = k; in_dec_err = dec; in_disp_err = disp;
  endtask

  task automatic send_block(int n, bit with_set, bit with_errs);
    if (with_set) begin
      drive(8'hBC, 1'b1, 1'b0, 1'b0);
      exp_q.push_back({3'b000, 1'b1, 8'hBC});
      for (int s = 0; s < 3; s++) begin
        drive(8'h1C, 1'b1, 1'b0, 1'b0);
        skp_in++;
      end
    end
    for (int j = 0; j < n; j++) begin
      if (with_errs && j == 40) begin          // R3: errored COM look-alike -> EDB
        drive(8'hBC, 1'b1, 1'b1, 1'b0);
        exp_q.push_back({3'b100, 1'b1, 8'hFE});
      end else if (with_errs && j == 90) begin // R4
        drive(dcnt, 1'b0, 1'b0, 1'b1);
        exp_q.push_back({3'b111, 1'b0, dcnt});
      end else if (with_errs && j == 120) begin // R11: decode beats disparity
        drive(dcnt, 1'b0, 1'b1, 1'b1);
        exp_q.push_back({3'b100, 1'b1, 8'hFE});
      end else if (with_errs && j == 150) begin // R5: stray K28.0 is data
        drive(8'h1C, 1'b1, 1'b0, 1'b0);
        exp_q.push_back({3'b000, 1'b1, 8'h1C});
      end else begin
        drive(dcnt, 1'b0, 1'b0, 1'b0);
        exp_q.push_back({3'b000, 1'b0, dcnt});
      end
      dcnt++;
    end
  endtask

  // Reference comparison on every read clock
  always @(negedge rd_clk) begin
    if (mon_en && !done) begin
      if (out_valid) begin
        check(out_status != 3'b110, "R10", "underflow with valid", out_status, 0);
        if (out_k && out_data == 8'h1C && ctx) begin
          skp_out++;
          check(out_status == 3'b000 || out_status == 3'b001 || out_status == 3'b010,
                "R7", "skip status", out_status, 0);
          if (out_status == 3'b001) begin adds++; set_adds++; end
          if (out_status == 3'b010) begin dels++; set_dels++; end
          check(set_adds <= 1 && set_dels <= 1, "R8", "adjusts per set", set_adds + set_dels, 1);
          ctx = 1;
        end else begin
          bit [11:0] e;
          check(out_status != 3'b001, "R7", "add on non-skip", out_status, 0);
          if (out_status == 3'b101) begin            // R9
            int dropped = 0;
            ovfs++;
            while (exp_q.size() > 0 && exp_q[0][8:0] != {out_k, out_data}) begin
              void'(exp_q.pop_front());
              dropped++;
            end
            check(dropped >= 1, "R9", "overflow without dropped symbol", dropped, 1);
          end
          if (exp_q.size() == 0) begin
            check(0, "R2", "unexpected output symbol", {out_k, out_data}, 0);
          end else begin
            e = exp_q.pop_front();
            check({out_k, out_data} == e[8:0], "R2", "symbol", {out_k, out_data}, e[8:0]);
            if (out_status == 3'b101) begin
              check(e[11:9] == 3'b000, "R11", "overflow vs error", out_status, e[11:9]);
            end else if (e[11:9] == 3'b000 && out_status == 3'b010) begin
              dels++; set_dels++;
              check(ctx, "R6", "delete report outside set", 0, 1);
              check(set_dels <= 1, "R8", "deletes per set", set_dels, 1);
            end else begin
              check(out_status == e[11:9], "R3", "status (R4/R11)", out_status, e[11:9]);
            end
          end
          if (out_k && out_data == 8'hBC) begin
            set_adds = 0; set_dels = 0; ctx = 1;
          end else begin
            ctx = 0;
          end
        end
      end else begin
        check(out_status == 3'b000 || out_status == 3'b110, "R10", "idle status", out_status, 3'b110);
        if (out_status == 3'b110) unders++;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge rd_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5) @(negedge rd_clk);
    rd_rst = 1'b0;
    @(negedge wr_clk);
    wr_rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge rd_clk);
      check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
      check(out_status == 3'b000, "R1", "status after reset", out_status, 0);
    end
    mon_en = 1;
    wr_half = 9.997;                                   // write 300 ppm fast
    for (int b = 0; b < 100; b++) send_block(196, 1'b1, 1'b1);
    wr_half = 10.003;                                  // write 300 ppm slow
    for (int b = 0; b < 150; b++) send_block(196, 1'b1, 1'b1);
    wr_half = 9.8;                                     // overrun, no sets
    for (int b = 0; b < 8; b++) send_block(196, 1'b0, 1'b0);
    @(negedge wr_clk);
    in_valid = 1'b0;
    repeat (200) @(negedge rd_clk);
    done = 1;
    check(exp_q.size() == 0, "R2", "symbols left undelivered", exp_q.size(), 0);
    check(skp_out == skp_in - dels + adds, "R6", "skip balance (R7)", skp_out, skp_in - dels + adds);
    check(dels >= 1, "R6", "deletions seen", dels, 1);
    check(adds >= 1, "R7", "insertions seen", adds, 1);
    check(ovfs >= 1, "R9", "overflow reports", ovfs, 1);
    check(unders >= 1, "R10", "underflow reports", unders, 1);
    finish_run();
  end
endmodule